// File: doc/BRIEF.md
# Calendar Clock with Write-Busy Flags

This block keeps wall-clock time and a calendar date, advanced by a one-cycle tick that marks each elapsed second. Hours, minutes and seconds live in one register; day, month, a 7-bit year offset and an explicit leap bit live in a second register. When the time passes midnight the date advances, using the month lengths and, for February, the leap bit.

Software reads and writes both registers through a small register port. A write does not land at once. The written value is parked, and a busy flag for that register stays set for a parameterised number of ticks. On the last of those ticks the new value replaces the running one and the flag drops. Until then the old value keeps counting and can still be read. Time and date can move between two reads, so a consistent snapshot needs both registers read again until the values repeat.

Top module: `cal_clock_top`

## Requirements
- R1: After a synchronous active-low reset the time reads 00:00:00, the date reads day 1, month 1, year offset 0 with the leap bit clear (0x0000_0101), and both busy flags read 0.
- R2: The time word packs seconds in bits 5:0, minutes in bits 13:8 and hours in bits 20:16. Each tick advances it by one second, with seconds wrapping 59 to 0 into minutes, minutes wrapping 59 to 0 into hours, and hours wrapping 23 to 0. Without a tick it holds.
- R3: The date word packs the day in bits 4:0, the 1-based month (January = 1) in bits 11:8, the year offset from 1970 in bits 22:16 and the leap bit in bit 23. Other read bits are 0.
- R4: Register addresses are 0 for time, 1 for date and 2 for status. A write to address 0 sets status bit 0 from the next cycle. The bit stays set for BUSY_TICKS ticks. On the last of those ticks the written time becomes the current time and the bit clears.
- R5: A write to address 1 behaves the same way through status bit 1 and the date register.
- R6: A write to a register whose busy flag is set is ignored. The value that lands is the one accepted first.
- R7: While a write is pending, the readable register keeps counting from its old value.
- R8: A tick that leaves 23:59:59 advances the day. After the last day of a month (31 or 30 days) the date goes to day 1 of the next month.
- R9: February has 28 days when the leap bit is 0 and 29 days when it is 1.
- R10: After December 31 the date goes to January 1 of the next year offset. The leap bit is recomputed as true when 1970 plus the offset is divisible by 4.
- R11: Year offset 127 (2097) rolls over to offset 0.
- R12: On a tick where a pending write lands, the landed value takes precedence. A landing time value produces no midnight carry, and a landing date value overrides a midnight advance on that tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse per elapsed second |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 time, 1 date, 2 status |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |

## Verification
The bench drives midnight crossings at the end of a 31-day month, a 30-day month, February in common and leap years, New Year into a leap year, and the wrap from offset 127 to 0. A wrong month table or a leap bit read the wrong way shows up as a day 29, 30 or 31 that should not exist, or as a missing February 29. It lands writes so that the landing tick coincides with 23:59:59. A design that lets the midnight carry win would bump the day after a time write, or would store the written day plus one. It also writes a register again while its flag is still set, and issues reads during the busy window. A design that accepts that second write would land the wrong value, and one that freezes or blanks the register during the window would read back the wrong value.

// File: rtl/cal_pkg.sv
// Package: shared field types and calendar helpers for the calendar clock.
// Assumes the year offset counts from YEAR_BASE and that the leap rule
// "divisible by 4" is exact over the supported span.
package cal_pkg;

    localparam int SEC_W   = 6;
    localparam int MIN_W   = 6;
    localparam int HOUR_W  = 5;
    localparam int DAY_W   = 5;
    localparam int MON_W   = 4;
    localparam int YEAR_W  = 7;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 2;
    localparam logic [10:0] YEAR_BASE = 11'd1970;

    // Bit positions inside the register words
    localparam int SEC_LSB  = 0;
    localparam int MIN_LSB  = 8;
    localparam int HOUR_LSB = 16;
    localparam int DAY_LSB  = 0;
    localparam int MON_LSB  = 8;
    localparam int YEAR_LSB = 16;
    localparam int LEAP_BIT = 23;

    localparam logic [ADDR_W-1:0] ADDR_TIME   = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_DATE   = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd2;

    typedef struct packed {
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  min;
        logic [SEC_W-1:0]  sec;
    } tod_t;

    typedef struct packed {
        logic              leap;
        logic [YEAR_W-1:0] year;
        logic [MON_W-1:0]  month;
        logic [DAY_W-1:0]  day;
    } cal_date_t;

    // Number of days in a 1-based month, February taken from the leap bit
    function automatic logic [DAY_W-1:0] month_len(input logic [MON_W-1:0] m,
                                                   input logic leap);
        logic [DAY_W-1:0] n;
        case (m)
            4'd2:                      n = leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   n = 5'd30;
            default:                   n = 5'd31;
        endcase
        return n;
    endfunction

    // Leap rule for a year offset: (base + offset) divisible by four
    function automatic logic leap_of(input logic [YEAR_W-1:0] off);
        logic [1:0] low;
        low = YEAR_BASE[1:0] + off[1:0];
        return (low == 2'd0);
    endfunction

endpackage

// File: rtl/cal_write_gate.sv
// Module: holds one register write as pending and raises a busy flag.
// The flag holds for BUSY_TICKS ticks. On the last of them commit_o
// pulses with the parked value on pend_o. Writes that arrive while
// busy are dropped. Assumes BUSY_TICKS >= 1.
module cal_write_gate #(
    parameter int BUSY_TICKS = 2,
    parameter int W          = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic         busy_o,
    output logic         commit_o,
    output logic [W-1:0] pend_o
);
    localparam int CNT_W = $clog2(BUSY_TICKS + 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic [W-1:0]     pend_q;

    assign busy_o   = busy_q;
    assign pend_o   = pend_q;
    assign commit_o = tick_i && busy_q && (cnt_q == CNT_W'(1));

    // Accept a write when idle, then count ticks down to the landing tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            pend_q <= '0;
        end else if (wr_i && !busy_q) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(BUSY_TICKS);
            pend_q <= wdata_i;
        end else if (tick_i && busy_q) begin
            cnt_q <= cnt_q - CNT_W'(1);
            if (cnt_q == CNT_W'(1)) busy_q <= 1'b0;
        end
    end

    AST_BUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !busy_q) |=> busy_q) else $error("busy not raised"); // R4
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !tick_i) |=> busy_q) else $error("busy dropped early"); // R4
    AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> $stable(pend_q)) else $error("pending value overwritten"); // R6
endmodule

// File: rtl/cal_tod_cnt.sv
// Module: time-of-day counter. It advances one second per tick and loads
// a committed value instead of counting on a landing tick. It signals a
// midnight carry only when it counts out of 23:59:59.
module cal_tod_cnt
    import cal_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick_i,
    input  logic  commit_i,
    input  tod_t  load_i,
    output tod_t  tod_o,
    output logic  carry_o
);
    tod_t tod_q;
    tod_t tod_nxt;
    logic at_midnight;

    assign tod_o       = tod_q;
    assign at_midnight = (tod_q.sec == 6'd59) && (tod_q.min == 6'd59) && (tod_q.hour == 5'd23);
    assign carry_o     = tick_i && !commit_i && at_midnight;

    // Next second with cascaded wraps
    always_comb begin
        tod_nxt = tod_q;
        if (tod_q.sec == 6'd59) begin
            tod_nxt.sec = '0;
            if (tod_q.min == 6'd59) begin
                tod_nxt.min = '0;
                tod_nxt.hour = (tod_q.hour == 5'd23) ? '0 : tod_q.hour + 5'd1;
            end else begin
                tod_nxt.min = tod_q.min + 6'd1;
            end
        end else begin
            tod_nxt.sec = tod_q.sec + 6'd1;
        end
    end

    // Time register: landing value wins, else count on tick
    always_ff @(posedge clk) begin
        if (!rst_n)          tod_q <= '0;
        else if (commit_i)   tod_q <= load_i;
        else if (tick_i)     tod_q <= tod_nxt;
    end

    AST_TOD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(tod_q)) else $error("time moved without tick"); // R2
    AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !commit_i && tod_q.sec < 6'd59) |=> (tod_q.sec == $past(tod_q.sec) + 6'd1))
        else $error("second did not step"); // R2
endmodule

// File: rtl/cal_date_cnt.sv
// Module: calendar date register. It advances one day on a midnight
// carry using month lengths and the leap bit, rolls month and year, and
// recomputes the leap bit at New Year. A committed write overrides the carry.
module cal_date_cnt
    import cal_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      carry_i,
    input  logic      commit_i,
    input  cal_date_t load_i,
    output cal_date_t date_o
);
    cal_date_t date_q;
    cal_date_t date_nxt;
    logic      last_day;

    assign date_o   = date_q;
    assign last_day = (date_q.day >= month_len(date_q.month, date_q.leap));

    // Following calendar day
    always_comb begin
        date_nxt = date_q;
        if (last_day) begin
            date_nxt.day = 5'd1;
            if (date_q.month >= 4'd12) begin
                date_nxt.month = 4'd1;
                date_nxt.year  = date_q.year + 7'd1;
                date_nxt.leap  = leap_of(date_q.year + 7'd1);
            end else begin
                date_nxt.month = date_q.month + 4'd1;
            end
        end else begin
            date_nxt.day = date_q.day + 5'd1;
        end
    end

    // Date register: landing value wins over the midnight advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            date_q <= '{leap: 1'b0, year: '0, month: 4'd1, day: 5'd1};
        end else if (commit_i) begin
            date_q <= load_i;
        end else if (carry_i) begin
            date_q <= date_nxt;
        end
    end

    AST_DATE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!carry_i && !commit_i) |=> $stable(date_q)) else $error("date moved"); // R8
    AST_MONTH_START: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_i && !commit_i && last_day) |=> (date_q.day == 5'd1))
        else $error("month did not restart"); // R8
endmodule

// File: rtl/cal_clock_top.sv
// Module: calendar clock top. It decodes the register port, routes writes
// through one busy gate per register, and ties the time counter's
// midnight carry to the date register. Reads are combinational.
// Assumes tick_i is a single-cycle pulse.
module cal_clock_top
    import cal_pkg::*;
#(
    parameter int BUSY_TICKS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic [DATA_W-1:0]   rdata_o
);
    localparam int TOD_W  = $bits(tod_t);
    localparam int DATE_W = $bits(cal_date_t);

    tod_t      wr_tod, pend_tod, cur_tod;
    cal_date_t wr_date, pend_date, cur_date;
    logic      tod_busy, tod_commit, date_busy, date_commit, day_carry;
    logic      wr_tod_sel, wr_date_sel;
    logic      unused_wdata;

    assign wr_tod_sel  = wr_en_i && (addr_i == ADDR_TIME);
    assign wr_date_sel = wr_en_i && (addr_i == ADDR_DATE);

    // Field extraction from the write word
    assign wr_tod  = '{hour: wdata_i[HOUR_LSB +: HOUR_W],
                       min:  wdata_i[MIN_LSB  +: MIN_W],
                       sec:  wdata_i[SEC_LSB  +: SEC_W]};
    assign wr_date = '{leap:  wdata_i[LEAP_BIT],
                       year:  wdata_i[YEAR_LSB +: YEAR_W],
                       month: wdata_i[MON_LSB  +: MON_W],
                       day:   wdata_i[DAY_LSB  +: DAY_W]};
    assign unused_wdata = ^{wdata_i[31:24], wdata_i[15:14], wdata_i[7:6]};

    cal_write_gate #(.BUSY_TICKS(BUSY_TICKS), .W(TOD_W)) u_tod_gate (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_i(wr_tod_sel),
        .wdata_i(wr_tod), .busy_o(tod_busy), .commit_o(tod_commit), .pend_o(pend_tod)
    );

    cal_write_gate #(.BUSY_TICKS(BUSY_TICKS), .W(DATE_W)) u_date_gate (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_i(wr_date_sel),
        .wdata_i(wr_date), .busy_o(date_busy), .commit_o(date_commit), .pend_o(pend_date)
    );

    cal_tod_cnt u_tod (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .commit_i(tod_commit),
        .load_i(pend_tod), .tod_o(cur_tod), .carry_o(day_carry)
    );

    cal_date_cnt u_date (
        .clk(clk), .rst_n(rst_n), .carry_i(day_carry), .commit_i(date_commit),
        .load_i(pend_date), .date_o(cur_date)
    );

    // Read multiplexer packing fields back into register words
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_TIME: begin
                rdata_o[HOUR_LSB +: HOUR_W] = cur_tod.hour;
                rdata_o[MIN_LSB  +: MIN_W]  = cur_tod.min;
                rdata_o[SEC_LSB  +: SEC_W]  = cur_tod.sec;
            end
            ADDR_DATE: begin
                rdata_o[LEAP_BIT]           = cur_date.leap;
                rdata_o[YEAR_LSB +: YEAR_W] = cur_date.year;
                rdata_o[MON_LSB  +: MON_W]  = cur_date.month;
                rdata_o[DAY_LSB  +: DAY_W]  = cur_date.day;
            end
            ADDR_STATUS: begin
                rdata_o[0] = tod_busy;
                rdata_o[1] = date_busy;
            end
            default: rdata_o = '0;
        endcase
    end

    AST_TOD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        tod_commit |=> (cur_tod == $past(pend_tod))) else $error("time write lost"); // R12
    AST_DATE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        date_commit |=> (cur_date == $past(pend_date))) else $error("date write lost"); // R12
    AST_NO_CARRY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tod_commit && !date_commit) |=> $stable(cur_date)) else $error("carry on time load"); // R12
endmodule

// File: tb/tb_cal_clock_top.sv
// Bench: a behavioural model updated each clock and compared against
// rdata_o on every falling edge, plus directed register reads.
module tb_cal_clock_top;
    localparam int CLK_PERIOD = 10;
    localparam int BUSY = 2;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        tick_i = 0;
    logic        wr_en_i = 0;
    logic [1:0]  addr_i = 0;
    logic [31:0] wdata_i = 0;
    logic [31:0] rdata_o;

    int n_checks = 0;
    int n_fail = 0;
    string cur_req = "R1";
    bit started = 0;
    bit finished = 0;

    // model state
    int m_h, m_m, m_s, m_d, m_mo, m_y, m_lp;
    int m_tb, m_tc, m_db, m_dc;
    int p_h, p_m, p_s, p_d, p_mo, p_y, p_lp;
    int tland, dland, carry;

    cal_clock_top #(.BUSY_TICKS(BUSY)) dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int mdays(int mo, int lp);
        if (mo == 2) return lp ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [31:0] exp_rd(logic [1:0] a);
        case (a)
            2'd0: return 32'((m_h << 16) | (m_m << 8) | m_s);
            2'd1: return 32'((m_lp << 23) | (m_y << 16) | (m_mo << 8) | m_d);
            2'd2: return 32'((m_db << 1) | m_tb);
            default: return 32'd0;
        endcase
    endfunction

    // Reference model, evaluated on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_h = 0; m_m = 0; m_s = 0; m_d = 1; m_mo = 1; m_y = 0; m_lp = 0;
            m_tb = 0; m_tc = 0; m_db = 0; m_dc = 0;
            started = 1;
        end else begin
            tland = (tick_i && m_tb && m_tc == 1);
            dland = (tick_i && m_db && m_dc == 1);
            carry = 0;
            if (tland) begin
                m_h = p_h; m_m = p_m; m_s = p_s;
            end else if (tick_i) begin
                m_s++;
                if (m_s == 60) begin
                    m_s = 0; m_m++;
                    if (m_m == 60) begin
                        m_m = 0; m_h++;
                        if (m_h == 24) begin m_h = 0; carry = 1; end
                    end
                end
            end
            if (dland) begin
                m_d = p_d; m_mo = p_mo; m_y = p_y; m_lp = p_lp;
            end else if (carry) begin
                if (m_d >= mdays(m_mo, m_lp)) begin
                    m_d = 1;
                    if (m_mo >= 12) begin
                        m_mo = 1; m_y = (m_y + 1) % 128;
                        m_lp = ((1970 + m_y) % 4 == 0);
                    end else m_mo++;
                end else m_d++;
            end
            if (wr_en_i && addr_i == 0 && !m_tb) begin
                m_tb = 1; m_tc = BUSY;
                p_h = int'(wdata_i[20:16]); p_m = int'(wdata_i[13:8]); p_s = int'(wdata_i[5:0]);
            end else if (tick_i && m_tb) begin
                m_tc--; if (m_tc == 0) m_tb = 0;
            end
            if (wr_en_i && addr_i == 1 && !m_db) begin
                m_db = 1; m_dc = BUSY;
                p_d = int'(wdata_i[4:0]); p_mo = int'(wdata_i[11:8]);
                p_y = int'(wdata_i[22:16]); p_lp = int'(wdata_i[23]);
            end else if (tick_i && m_db) begin
                m_dc--; if (m_dc == 0) m_db = 0;
            end
        end
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (started && !finished) begin
            n_checks++;
            if (rdata_o !== exp_rd(addr_i)) begin
                n_fail++;
                $display("FAIL %s: addr %0d actual %h expected %h", cur_req, addr_i, rdata_o, exp_rd(addr_i));
            end
        end
    end

    task automatic cyc(input bit tk, input logic [1:0] a, input bit we, input logic [31:0] d);
        @(posedge clk); #1;
        tick_i = tk; addr_i = a; wr_en_i = we; wdata_i = d;
    endtask

    task automatic second();
        cyc(1, 0, 0, 0); cyc(0, 1, 0, 0); cyc(0, 2, 0, 0);
    endtask

    task automatic check_reg(input logic [1:0] a, input logic [31:0] exp, input string req);
        cyc(0, a, 0, 0);
        @(negedge clk);
        n_checks++;
        if (rdata_o !== exp) begin
            n_fail++;
            $display("FAIL %s: addr %0d actual %h expected %h", req, a, rdata_o, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
        cyc(0, a, 1, d);
    endtask

    task automatic set_time(input logic [31:0] v);
        write_reg(0, v);
        for (int i = 0; i < BUSY; i++) second();
    endtask

    task automatic set_date(input logic [31:0] v);
        write_reg(1, v);
        for (int i = 0; i < BUSY; i++) second();
    endtask

    task automatic midnight();
        set_time(32'h0017_3B3B);
        second();
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        cur_req = "R1";
        check_reg(0, 32'h0000_0000, "R1");
        check_reg(1, 32'h0000_0101, "R1");
        check_reg(2, 32'h0000_0000, "R1");

        cur_req = "R2";
        for (int i = 0; i < 70; i++) second();
        check_reg(0, 32'h0000_010A, "R2");

        cur_req = "R4";
        write_reg(0, 32'h0017_3B37);
        check_reg(2, 32'h0000_0001, "R4");
        cur_req = "R6";
        write_reg(0, 32'h0001_0203);
        cur_req = "R7";
        second();
        check_reg(0, 32'h0000_010B, "R7");
        check_reg(2, 32'h0000_0001, "R4");
        second();
        check_reg(0, 32'h0017_3B37, "R6");
        check_reg(2, 32'h0000_0000, "R4");

        cur_req = "R8";
        for (int i = 0; i < 5; i++) second();
        check_reg(0, 32'h0000_0000, "R2");
        check_reg(1, 32'h0000_0102, "R8");

        cur_req = "R5";
        write_reg(1, 32'h0000_011F);
        check_reg(2, 32'h0000_0002, "R5");
        second(); second();
        check_reg(1, 32'h0000_011F, "R5");
        check_reg(2, 32'h0000_0000, "R5");
        cur_req = "R8";
        midnight();
        check_reg(1, 32'h0000_0201, "R8");
        set_date(32'h0000_041E);
        midnight();
        check_reg(1, 32'h0000_0501, "R8");

        cur_req = "R9";
        set_date(32'h0000_021C);
        midnight();
        check_reg(1, 32'h0000_0301, "R9");
        set_date(32'h0082_021C);
        midnight();
        check_reg(1, 32'h0082_021D, "R9");
        midnight();
        check_reg(1, 32'h0082_0301, "R9");

        cur_req = "R10";
        set_date(32'h0001_0C1F);
        midnight();
        check_reg(1, 32'h0082_0101, "R10");
        set_date(32'h0082_0C1F);
        midnight();
        check_reg(1, 32'h0003_0101, "R10");

        cur_req = "R11";
        set_date(32'h007F_0C1F);
        midnight();
        check_reg(1, 32'h0000_0101, "R11");

        cur_req = "R12";
        set_time(32'h0017_3B38);
        second(); second();
        write_reg(1, 32'h0000_0A05);
        second(); second();
        check_reg(1, 32'h0000_0A05, "R12");
        check_reg(0, 32'h0000_0000, "R12");
        set_time(32'h0017_3B3A);
        write_reg(0, 32'h0001_0000);
        second(); second();
        check_reg(0, 32'h0001_0000, "R12");
        check_reg(1, 32'h0000_0A05, "R12");

        cur_req = "R3";
        check_reg(3, 32'h0000_0000, "R3");
        cyc(0, 0, 0, 0);
        @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule